// File: doc/BRIEF.md
# Edge-Capture GPIO Bank with Interrupt

This block is a 48-channel general-purpose I/O bank reached through a narrow 16-bit register bus. Each channel drives its pin through an open-drain latch and can be read back at any time through a two-flop synchroniser. There is no direction register. A channel behaves as an input while its latch holds 0, because the pin is then released and follows its external level or the pull-up.

The low 40 channels also watch their synchronised inputs for a transition, and each chooses the polarity of that transition. When the chosen edge occurs and capture is enabled for that channel, a sticky flag is set. The host clears it by writing a one to it. A flag whose interrupt enable is set drives the single level interrupt output. The top eight channels are plain I/O only.

The channels form three groups of sixteen, each with its own 16-byte register window. The write map and the read map are separate, so one offset can reach different registers depending on the direction of the access.

Top module: `gpio_edge_bank`

## Requirements
- R1: Group windows start at 0x40, 0x50 and 0x60 and cover channels 0-15, 16-31 and 32-47. The low four address bits select the register. Reads at any unlisted offset, or at any address outside the three windows, return 0. Writes outside the windows change nothing.
- R2: In write space, offset 0x2 is interrupt enable, 0x4 is edge select, 0x6 is capture enable and 0x8 is the output latch. In read space, these three control registers read back at 0xA, 0xC and 0xE respectively. Offsets 0x2, 0x4 and 0x6 read as 0.
- R3: `pin_pull_low[n]` equals output latch bit n, where 1 pulls the pin low and 0 releases it. Read offset 0x0 returns the synchronised pin levels of the group.
- R4: Edge select bit 1 detects a rising edge and bit 0 detects a falling edge. The opposite transition never sets the flag.
- R5: A capture flag sets only while its capture enable bit is 1. The flag reads at read offset 0x8 and stays set until the host clears it.
- R6: Writing to write offset 0xA clears every flag whose data bit is 1 and leaves the other flags unchanged. If a clear and a new edge land in the same cycle, the flag stays set.
- R7: `irq` is high exactly while some capture flag and its interrupt enable are both 1.
- R8: For channels 40-47, the capture enable, interrupt enable, edge select and flag bits always read 0 and never set. The latch and pin read of these channels still work.
- R9: Reset clears all enables, edge selects, flags and latches. After reset, `pin_pull_low` is 0 and `irq` is 0.
- R10: After a pin changes, the synchronised read and the flag change at the second and third rising clock edges respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pin_in | input | 48 | External pin levels |
| pin_pull_low | output | 48 | Open-drain pull-down enable for each pin |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach from the ports is a flag-clear write that lands in the same cycle as the detection of a new edge on a flag that is already set. Getting there requires counting the two synchroniser stages and the history flop, so that the write strobe is present on exactly the third rising edge after the pin moves. The bench sets the flag first, returns the pin to its idle level, moves it again on a falling clock edge, and waits two rising edges. It then issues the clear so that the strobe is sampled on the edge that also records the new event. Channel 40 is toggled next to channel 32 with every group C enable written high, to show that the upper channels never flag.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned GRP_W = 16;
  typedef logic [GRP_W-1:0] grp_vec_t;

  // write-space offsets
  localparam logic [3:0] WOFS_INTEN   = 4'h2;
  localparam logic [3:0] WOFS_EDGESEL = 4'h4;
  localparam logic [3:0] WOFS_CAPEN   = 4'h6;
  localparam logic [3:0] WOFS_LATCH   = 4'h8;
  localparam logic [3:0] WOFS_FLAGCLR = 4'hA;
  // read-space offsets
  localparam logic [3:0] ROFS_PINS    = 4'h0;
  localparam logic [3:0] ROFS_FLAGS   = 4'h8;
  localparam logic [3:0] ROFS_INTEN   = 4'hA;
  localparam logic [3:0] ROFS_EDGESEL = 4'hC;
  localparam logic [3:0] ROFS_CAPEN   = 4'hE;

  // channels of a group that own edge logic
  function automatic grp_vec_t edge_mask(int unsigned grp, int unsigned edge_ch);
    grp_vec_t m;
    for (int unsigned i = 0; i < GRP_W; i++)
      m[i] = ((grp * GRP_W + i) < edge_ch);
    return m;
  endfunction

  // per-bit transition of the selected polarity (sel=1 rising, sel=0 falling)
  function automatic grp_vec_t edge_hits(grp_vec_t now, grp_vec_t prev, grp_vec_t sel);
    return (sel & now & ~prev) | (~sel & ~now & prev);
  endfunction

  // next flag state: clear first, then new events win
  function automatic grp_vec_t flag_next(grp_vec_t cur, grp_vec_t clr, grp_vec_t ev);
    return (cur & ~clr) | ev;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 48,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_group.sv
module gpio_group
  import gpio_bank_pkg::*;
#(
  parameter int unsigned GRP_IDX = 0,
  parameter int unsigned EDGE_CH = 40
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_sel,
  input  logic [3:0] ofs,
  input  grp_vec_t wdata,
  input  grp_vec_t pins_sync,
  output grp_vec_t latch_q,
  output grp_vec_t inten_q,
  output grp_vec_t edgesel_q,
  output grp_vec_t capen_q,
  output grp_vec_t flag_q,
  output grp_vec_t event_o,
  output grp_vec_t clr_o,
  output grp_vec_t rdata
);
  localparam grp_vec_t EMASK = edge_mask(GRP_IDX, EDGE_CH);

  grp_vec_t pins_prev;
  logic wr_inten, wr_edge, wr_capen, wr_latch, wr_clr;

  assign wr_inten = wr_sel && (ofs == WOFS_INTEN);
  assign wr_edge  = wr_sel && (ofs == WOFS_EDGESEL);
  assign wr_capen = wr_sel && (ofs == WOFS_CAPEN);
  assign wr_latch = wr_sel && (ofs == WOFS_LATCH);
  assign wr_clr   = wr_sel && (ofs == WOFS_FLAGCLR);

  assign event_o = edge_hits(pins_sync, pins_prev, edgesel_q) & capen_q & EMASK;
  assign clr_o   = wr_clr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pins_prev <= '1;
      latch_q   <= '0;
      inten_q   <= '0;
      edgesel_q <= '0;
      capen_q   <= '0;
      flag_q    <= '0;
    end else begin
      pins_prev <= pins_sync;
      if (wr_latch) latch_q   <= wdata;
      if (wr_inten) inten_q   <= wdata & EMASK;
      if (wr_edge)  edgesel_q <= wdata & EMASK;
      if (wr_capen) capen_q   <= wdata & EMASK;
      flag_q <= flag_next(flag_q, clr_o, event_o) & EMASK;
    end
  end

  always_comb begin
    unique case (ofs)
      ROFS_PINS:    rdata = pins_sync;
      ROFS_FLAGS:   rdata = flag_q;
      ROFS_INTEN:   rdata = inten_q;
      ROFS_EDGESEL: rdata = edgesel_q;
      ROFS_CAPEN:   rdata = capen_q;
      default:      rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_GRP   = 3,
  parameter int unsigned EDGE_CH   = 40,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 'h40,
  parameter int unsigned STRIDE    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [GRP_W-1:0]           bus_wdata,
  output logic [GRP_W-1:0]           bus_rdata,
  input  logic [NUM_GRP*GRP_W-1:0]   pin_in,
  output logic [NUM_GRP*GRP_W-1:0]   pin_pull_low,
  output logic                       irq
);
  localparam int unsigned NCH   = NUM_GRP * GRP_W;
  localparam int unsigned OFS_W = $clog2(STRIDE);
  localparam int unsigned GI_W  = ADDR_W - OFS_W;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_GRP * STRIDE);

  logic [NCH-1:0] pins_sync;
  logic [NCH-1:0] flag_all, inten_all, edgesel_all, capen_all, latch_all;
  logic [NCH-1:0] event_all, clr_all;
  logic [ADDR_W-1:0] win_off;
  logic [GI_W-1:0]   grp_idx;
  logic              in_win;
  grp_vec_t          grp_rdata [NUM_GRP];

  assign win_off = bus_addr - BASE;
  assign grp_idx = win_off[ADDR_W-1:OFS_W];
  assign in_win  = (bus_addr >= BASE) && (win_off < SPAN);

  gpio_sync #(.W(NCH), .RST_VAL({NCH{1'b1}})) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_sync)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic wr_sel;
    assign wr_sel = bus_wr && in_win && (grp_idx == GI_W'(g));
    gpio_group #(.GRP_IDX(g), .EDGE_CH(EDGE_CH)) u_grp (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_sel    (wr_sel),
      .ofs       (bus_addr[3:0]),
      .wdata     (bus_wdata),
      .pins_sync (pins_sync[g*GRP_W +: GRP_W]),
      .latch_q   (latch_all[g*GRP_W +: GRP_W]),
      .inten_q   (inten_all[g*GRP_W +: GRP_W]),
      .edgesel_q (edgesel_all[g*GRP_W +: GRP_W]),
      .capen_q   (capen_all[g*GRP_W +: GRP_W]),
      .flag_q    (flag_all[g*GRP_W +: GRP_W]),
      .event_o   (event_all[g*GRP_W +: GRP_W]),
      .clr_o     (clr_all[g*GRP_W +: GRP_W]),
      .rdata     (grp_rdata[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int g = 0; g < NUM_GRP; g++)
      if (in_win && (grp_idx == GI_W'(g))) bus_rdata = grp_rdata[g];
  end

  assign pin_pull_low = latch_all;
  assign irq          = |(flag_all & inten_all);
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk #(
  parameter int unsigned NCH     = 48,
  parameter int unsigned EDGE_CH = 40
) (
  input logic           clk,
  input logic           rst_n,
  input logic           irq,
  input logic [NCH-1:0] flag_all,
  input logic [NCH-1:0] inten_all,
  input logic [NCH-1:0] capen_all,
  input logic [NCH-1:0] event_all,
  input logic [NCH-1:0] clr_all
);
  // R8: plain channels never hold capture state
  a_r8_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_all[NCH-1:EDGE_CH] == '0) && (capen_all[NCH-1:EDGE_CH] == '0));

  // R5: a flag stays set unless a clear hit it
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flag_all) & ~$past(clr_all)) & ~flag_all) == '0));

  // R5: a newly set flag required capture enable one cycle earlier
  a_r5_needs_capen: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_all & ~$past(flag_all) & ~$past(capen_all)) == '0));

  // R6: an event always leaves its flag set, even against a clear
  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(event_all) & ~flag_all) == '0));

  // R7: interrupt only with an enabled flag
  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((flag_all & inten_all) != '0));
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NCH(NCH), .EDGE_CH(EDGE_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .flag_all(flag_all),
  .inten_all(inten_all), .capen_all(capen_all),
  .event_all(event_all), .clr_all(clr_all)
);

// File: tb/gpio_edge_bank_bench.sv
module gpio_edge_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [47:0] ext_lvl = '1;
  logic [47:0] pin_in;
  logic [47:0] pin_pull_low;
  logic        irq;
  int          n_tests = 0;
  int          n_fail = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  // open-drain pin model
  assign pin_in = ext_lvl & ~pin_pull_low;

  gpio_edge_bank u_gpio_edge_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_pull_low(pin_pull_low), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  req;
    logic [7:0]  addr;
    logic [15:0] data;   // write data, or expected read value
  } vec_t;

  localparam int NV = 13;
  // covers R1, R2 and R8 register decode
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd2, 8'h42, 16'h00FF}, '{1'b0, 4'd2, 8'h4A, 16'h00FF},
    '{1'b1, 4'd2, 8'h54, 16'h1234}, '{1'b0, 4'd2, 8'h5C, 16'h1234},
    '{1'b1, 4'd8, 8'h66, 16'hFFFF}, '{1'b0, 4'd8, 8'h6E, 16'h00FF},
    '{1'b1, 4'd8, 8'h64, 16'hABCD}, '{1'b0, 4'd8, 8'h6C, 16'h00CD},
    '{1'b0, 4'd2, 8'h42, 16'h0000}, '{1'b0, 4'd1, 8'h70, 16'h0000},
    '{1'b0, 4'd1, 8'h3E, 16'h0000}, '{1'b1, 4'd1, 8'h7E, 16'hFFFF},
    '{1'b0, 4'd1, 8'h5E, 16'h0000}
  };

  task automatic chk(input string req, input logic [47:0] got, input logic [47:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // call only just after a falling edge
  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [15:0] exp);
    logic [15:0] v;
    @(negedge clk);
    rd(a, v);
    chk(req, {32'h0, v}, {32'h0, exp});
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic set_ext(input int ch, input logic lvl);
    @(negedge clk);
    ext_lvl[ch] = lvl;
    settle();
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R9 reset state
    chk("R9 pull", pin_pull_low, 48'h0);
    chk("R9 irq", {47'h0, irq}, 48'h0);
    rdchk("R9 inten", 8'h4A, 16'h0000);
    rdchk("R9 flags", 8'h48, 16'h0000);
    rdchk("R9 pins", 8'h40, 16'hFFFF);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
      else begin
        @(negedge clk);
        rd(VECS[i].addr, v);
        n_tests++;
        if (v !== VECS[i].data) begin
          n_fail++;
          $display("FAIL R%0d vector %0d: got %h expected %h", VECS[i].req, i, v, VECS[i].data);
        end
      end
    end
    wr(8'h42, 16'h0); wr(8'h54, 16'h0); wr(8'h66, 16'h0); wr(8'h64, 16'h0);

    // R3 open-drain latch and pin read
    wr(8'h48, 16'h0005);
    settle();
    chk("R3 pull", pin_pull_low, 48'h0000_0000_0005);
    rdchk("R3 pins low", 8'h40, 16'hFFFA);
    wr(8'h48, 16'h0000);
    set_ext(4, 1'b0);
    rdchk("R3 ext low", 8'h40, 16'hFFEF);
    set_ext(4, 1'b1);

    // R4 polarity: ch0 rising, ch1 falling, both captured
    wr(8'h46, 16'h0003);
    wr(8'h44, 16'h0001);
    set_ext(0, 1'b0);
    rdchk("R4 wrong edge", 8'h48, 16'h0000);
    set_ext(1, 1'b0);
    rdchk("R4 falling", 8'h48, 16'h0002);
    set_ext(0, 1'b1);
    rdchk("R4 rising", 8'h48, 16'h0003);

    // R5 capture disabled channel and stickiness
    set_ext(2, 1'b0);
    rdchk("R5 no capen", 8'h48, 16'h0003);
    set_ext(1, 1'b1);
    rdchk("R5 sticky", 8'h48, 16'h0003);

    // R7 interrupt level
    @(negedge clk);
    chk("R7 masked", {47'h0, irq}, 48'h0);
    wr(8'h42, 16'h0002);
    chk("R7 enabled", {47'h0, irq}, 48'h1);
    // R6 selective clear
    wr(8'h4A, 16'h0002);
    rdchk("R6 clear one", 8'h48, 16'h0001);
    chk("R7 drop", {47'h0, irq}, 48'h0);
    wr(8'h4A, 16'h0000);
    rdchk("R6 zero keeps", 8'h48, 16'h0001);

    // R10 latency on ch20 (group B bit 4, rising)
    wr(8'h56, 16'h0010);
    wr(8'h54, 16'h0010);
    set_ext(20, 1'b0);
    @(negedge clk);
    ext_lvl[20] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rd(8'h58, v);
    chk("R10 flag not yet", {32'h0, v}, 48'h0);
    rd(8'h50, v);
    chk("R10 pin synced", {32'h0, v}, 48'h0000_0000_FFFF);
    rdchk("R10 flag set", 8'h58, 16'h0010);

    // R6 race: clear sampled on the same edge as a new event
    set_ext(20, 1'b0);
    @(negedge clk);
    ext_lvl[20] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(8'h5A, 16'h0010);
    rdchk("R6 event wins", 8'h58, 16'h0010);
    wr(8'h5A, 16'h0010);
    rdchk("R6 clear", 8'h58, 16'h0000);

    // R8 upper channels
    wr(8'h66, 16'hFFFF); wr(8'h64, 16'hFFFF); wr(8'h62, 16'hFFFF);
    set_ext(40, 1'b0); set_ext(40, 1'b1);
    set_ext(32, 1'b0); set_ext(32, 1'b1);
    rdchk("R8 flags", 8'h68, 16'h0001);
    chk("R7 group C irq", {47'h0, irq}, 48'h1);
    wr(8'h68, 16'h8000);
    settle();
    chk("R8 pull 47", {47'h0, pin_pull_low[47]}, 48'h1);
    rdchk("R8 pin 47", 8'h60, 16'h7FFF);

    // R9 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 pull again", pin_pull_low, 48'h0);
    chk("R9 irq again", {47'h0, irq}, 48'h0);
    rdchk("R9 flags C", 8'h68, 16'h0000);
    rdchk("R9 inten C", 8'h6A, 16'h0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule